// File: doc/BRIEF.md
# Programmable Sum-of-Products Output Logic

This block computes a bank of general-purpose output states, each from a programmable sum of two product terms. A product term can take in the registered states of the first eight outputs, the general-purpose input pins, and one chosen status flag from every rail. Each input that a term uses can be inverted on its own. The rail flag is chosen by a type code per term. It can be a live flag or a sticky copy of that flag. The sticky copy holds until a clear strobe arrives, either from a register write or from input pins chosen for that purpose.

Each output goes through a delay stage with separate assert and deassert counts, measured in ticks of an external timebase strobe. An input change that does not last for the full count is filtered out. The resulting logical states are exported on `gpo_o`, and the sequencing logic uses them as dependencies. Configuration is loaded through a single-cycle register write port.

Top module: `gpo_logic`

## Requirements
- R1: Each output is the OR of two product terms. A term is the AND of its selected inputs, and each selected input is first XORed with its invert bit. In a term select word (default sizes), bits [3:0] select output feedback bits, [7:4] select general-purpose inputs, [11:8] select rails, and [15:12] hold the rail type code. The invert word uses the same positions for bits [11:0].
- R2: A term whose feedback, input and rail select bits are all zero contributes 0, whatever its invert bits and type code are.
- R3: A rail term reads only the flag that its type code names. Codes 0 to 7 are the live flags: 0 power good, 1 margin enable, 2 margin low, 3 overvoltage fault, 4 overvoltage warning, 5 undervoltage fault, 6 undervoltage warning, 7 turn-on time fault. Code 8+k reads the sticky copy of flag k. The flag of rail r, type k, is `rail_flag_i[r*8+k]`.
- R4: For power-good codes (0 and 8), a rail whose `rail_mon_i` bit is 0 is left out of the term. It is treated as if it were not selected.
- R5: A sticky flag sets one cycle after its live flag is high. It then holds until a clear. A clear comes from a write to address 32 (the data is ignored), or from any input pin whose bit is set in the clear-source register at address 33. When set and clear happen in the same cycle, the set wins.
- R6: Feedback uses each output's registered state. An output that depends on another output follows it one cycle later.
- R7: With an assert delay of D ticks, the output rises on the D-th tick after its term sum goes high. With D = 0, it rises on the next clock.
- R8: With a deassert delay of D ticks, the output falls on the D-th tick after its term sum goes low. With D = 0, it falls on the next clock.
- R9: If the term sum returns to the current output state before the delay expires, the pending count is discarded. The next change then starts counting again from zero.
- R10: Reset clears every output state, sticky flag and configuration register. Per-output register map: address o*8+0 is the term 0 select word, o*8+1 the term 0 invert word, o*8+2 the term 1 select word, o*8+3 the term 1 invert word, and o*8+4 the delays (assert in [15:0], deassert in [31:16]).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Delay timebase strobe, one cycle wide |
| cfg_we_i | input | 1 | Register write strobe |
| cfg_addr_i | input | ADDR_W | Register address |
| cfg_wdata_i | input | 32 | Register write data |
| gpi_i | input | NUM_GPI | General-purpose input pins |
| rail_flag_i | input | NUM_RAIL*NUM_FLAG | Live rail status flags |
| rail_mon_i | input | NUM_RAIL | Rail has voltage monitoring |
| gpo_o | output | NUM_OUT | Logical output states |

## Verification
Four outputs are set up at once with different term shapes and swept over 256 input patterns. The patterns combine every pin value, every monitoring mask and pseudo-random flag words, so each output bit separates a different rule:
- mixed inverted and plain pins;
- a rail type picked out while the other types carry complementary noise;
- power-good with unmonitored rails;
- terms that are empty apart from invert bits or a type code.

Directed sequences then cover the remaining rules:
- sticky flags are pulsed on a masked rail and on an unmasked rail, and cleared by command, by pin, and with set and clear together;
- a feedback chain shows the one-cycle lag;
- tick-counted delays are tried with glitches shorter than the count in both directions, which separates a restarted count from a resumed one.

// File: rtl/gpo_logic_pkg.sv
package gpo_logic_pkg;
  localparam int WORDS_PER_OUT = 8;
  localparam int W_T0_SEL = 0;
  localparam int W_T0_INV = 1;
  localparam int W_T1_SEL = 2;
  localparam int W_T1_INV = 3;
  localparam int W_DLY    = 4;
  localparam int DLY_HI_LSB = 16;
  // flag type indices within a rail
  localparam int FLAG_PG     = 0;
  localparam int FLAG_MRG_EN = 1;
  localparam int FLAG_MRG_LO = 2;
  localparam int FLAG_OV_F   = 3;
  localparam int FLAG_OV_W   = 4;
  localparam int FLAG_UV_F   = 5;
  localparam int FLAG_UV_W   = 6;
  localparam int FLAG_TON_F  = 7;

  function automatic int fb_width(int n_out);
    return (n_out < 8) ? n_out : 8;
  endfunction
endpackage

// File: rtl/gpo_cfg_regs.sv
module gpo_cfg_regs
  import gpo_logic_pkg::*;
#(
  parameter int NUM_OUT = 4,
  parameter int NUM_GPI = 4,
  parameter int SEL_W   = 16,
  parameter int IN_W    = 12,
  parameter int DLY_W   = 16,
  parameter int ADDR_W  = 6
) (
  input  logic                                   clk_i,
  input  logic                                   rst_ni,
  input  logic                                   we_i,
  input  logic [ADDR_W-1:0]                      addr_i,
  input  logic [31:0]                            wdata_i,
  output logic [NUM_OUT-1:0][1:0][SEL_W-1:0]     sel_o,
  output logic [NUM_OUT-1:0][1:0][IN_W-1:0]      inv_o,
  output logic [NUM_OUT-1:0][DLY_W-1:0]          asrt_dly_o,
  output logic [NUM_OUT-1:0][DLY_W-1:0]          deas_dly_o,
  output logic                                   clr_cmd_o,
  output logic [NUM_GPI-1:0]                     clr_src_o
);
  localparam int CLR_ADDR = NUM_OUT * WORDS_PER_OUT;
  localparam int SRC_ADDR = CLR_ADDR + 1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_o      <= '0;
      inv_o      <= '0;
      asrt_dly_o <= '0;
      deas_dly_o <= '0;
      clr_src_o  <= '0;
    end else if (we_i) begin
      for (int o = 0; o < NUM_OUT; o++) begin
        if (addr_i == ADDR_W'(o*WORDS_PER_OUT + W_T0_SEL)) sel_o[o][0] <= wdata_i[SEL_W-1:0];
        if (addr_i == ADDR_W'(o*WORDS_PER_OUT + W_T0_INV)) inv_o[o][0] <= wdata_i[IN_W-1:0];
        if (addr_i == ADDR_W'(o*WORDS_PER_OUT + W_T1_SEL)) sel_o[o][1] <= wdata_i[SEL_W-1:0];
        if (addr_i == ADDR_W'(o*WORDS_PER_OUT + W_T1_INV)) inv_o[o][1] <= wdata_i[IN_W-1:0];
        if (addr_i == ADDR_W'(o*WORDS_PER_OUT + W_DLY)) begin
          asrt_dly_o[o] <= wdata_i[DLY_W-1:0];
          deas_dly_o[o] <= wdata_i[DLY_HI_LSB +: DLY_W];
        end
      end
      if (addr_i == ADDR_W'(SRC_ADDR)) clr_src_o <= wdata_i[NUM_GPI-1:0];
    end
  end

  assign clr_cmd_o = we_i && (addr_i == ADDR_W'(CLR_ADDR));
endmodule

// File: rtl/gpo_stat_latch.sv
module gpo_stat_latch #(
  parameter int N = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] live_i,
  input  logic         clr_i,
  output logic [N-1:0] lat_o
);
  // set dominates clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lat_o <= '0;
    else         lat_o <= (lat_o & ~{N{clr_i}}) | live_i;
  end
endmodule

// File: rtl/gpo_term.sv
module gpo_term
  import gpo_logic_pkg::*;
#(
  parameter int FB_W     = 4,
  parameter int NUM_GPI  = 4,
  parameter int NUM_RAIL = 4,
  parameter int NUM_FLAG = 8,
  localparam int IDX_W   = $clog2(NUM_FLAG),
  localparam int TYPE_W  = IDX_W + 1,
  localparam int IN_W    = FB_W + NUM_GPI + NUM_RAIL,
  localparam int SEL_W   = IN_W + TYPE_W,
  localparam int NUM_LIVE = NUM_RAIL * NUM_FLAG
) (
  input  logic [SEL_W-1:0]    sel_i,
  input  logic [IN_W-1:0]     inv_i,
  input  logic [FB_W-1:0]     fb_i,
  input  logic [NUM_GPI-1:0]  gpi_i,
  input  logic [NUM_LIVE-1:0] live_i,
  input  logic [NUM_LIVE-1:0] lat_i,
  input  logic [NUM_RAIL-1:0] mon_i,
  output logic                hit_o
);
  logic [TYPE_W-1:0]   code;
  logic [IDX_W-1:0]    idx;
  logic [NUM_RAIL-1:0] flag;
  logic [NUM_RAIL-1:0] rail_m;
  logic [IN_W-1:0]     mask;
  logic [IN_W-1:0]     vec;

  always_comb begin
    code = sel_i[SEL_W-1 -: TYPE_W];
    idx  = code[IDX_W-1:0];
    for (int r = 0; r < NUM_RAIL; r++) begin
      int k;
      k = r*NUM_FLAG + int'(idx);
      flag[r] = code[IDX_W] ? lat_i[k] : live_i[k];
    end
    rail_m = sel_i[FB_W+NUM_GPI +: NUM_RAIL];
    if (idx == IDX_W'(FLAG_PG)) rail_m = rail_m & mon_i;  // unmonitored rails drop out
    mask  = {rail_m, sel_i[FB_W+NUM_GPI-1:0]};
    vec   = {flag, gpi_i, fb_i} ^ inv_i;
    hit_o = (|mask) && (&(~mask | vec));
  end
endmodule

// File: rtl/gpo_delay.sv
module gpo_delay #(
  parameter int DLY_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             raw_i,
  input  logic [DLY_W-1:0] asrt_dly_i,
  input  logic [DLY_W-1:0] deas_dly_i,
  output logic             out_o
);
  logic [DLY_W-1:0] dly;
  logic [DLY_W-1:0] cnt_q;

  assign dly = raw_i ? asrt_dly_i : deas_dly_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_o <= 1'b0;
      cnt_q <= '0;
    end else if (raw_i == out_o) begin
      cnt_q <= '0;  // glitch ended: discard pending count
    end else if (dly == '0) begin
      out_o <= raw_i;
      cnt_q <= '0;
    end else if (tick_i) begin
      if (cnt_q == dly - DLY_W'(1)) begin
        out_o <= raw_i;
        cnt_q <= '0;
      end else begin
        cnt_q <= cnt_q + DLY_W'(1);
      end
    end
  end
endmodule

// File: rtl/gpo_logic.sv
module gpo_logic
  import gpo_logic_pkg::*;
#(
  parameter int NUM_OUT  = 4,
  parameter int NUM_GPI  = 4,
  parameter int NUM_RAIL = 4,
  parameter int NUM_FLAG = 8,
  parameter int DLY_W    = 16,
  localparam int ADDR_W  = $clog2(NUM_OUT*WORDS_PER_OUT + 2)
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         tick_i,
  input  logic                         cfg_we_i,
  input  logic [ADDR_W-1:0]            cfg_addr_i,
  input  logic [31:0]                  cfg_wdata_i,
  input  logic [NUM_GPI-1:0]           gpi_i,
  input  logic [NUM_RAIL*NUM_FLAG-1:0] rail_flag_i,
  input  logic [NUM_RAIL-1:0]          rail_mon_i,
  output logic [NUM_OUT-1:0]           gpo_o
);
  localparam int FB_W     = fb_width(NUM_OUT);
  localparam int IDX_W    = $clog2(NUM_FLAG);
  localparam int IN_W     = FB_W + NUM_GPI + NUM_RAIL;
  localparam int SEL_W    = IN_W + IDX_W + 1;
  localparam int NUM_LIVE = NUM_RAIL * NUM_FLAG;

  logic [NUM_OUT-1:0][1:0][SEL_W-1:0] sel;
  logic [NUM_OUT-1:0][1:0][IN_W-1:0]  inv;
  logic [NUM_OUT-1:0][DLY_W-1:0]      asrt_dly;
  logic [NUM_OUT-1:0][DLY_W-1:0]      deas_dly;
  logic                               clr_cmd;
  logic [NUM_GPI-1:0]                 clr_src;
  logic                               lat_clr;
  logic [NUM_LIVE-1:0]                lat_q;
  logic [NUM_OUT-1:0]                 gpo_q;

  gpo_cfg_regs #(
    .NUM_OUT(NUM_OUT), .NUM_GPI(NUM_GPI), .SEL_W(SEL_W),
    .IN_W(IN_W), .DLY_W(DLY_W), .ADDR_W(ADDR_W)
  ) u_cfg (
    .clk_i, .rst_ni,
    .we_i(cfg_we_i), .addr_i(cfg_addr_i), .wdata_i(cfg_wdata_i),
    .sel_o(sel), .inv_o(inv), .asrt_dly_o(asrt_dly), .deas_dly_o(deas_dly),
    .clr_cmd_o(clr_cmd), .clr_src_o(clr_src)
  );

  assign lat_clr = clr_cmd | (|(gpi_i & clr_src));

  gpo_stat_latch #(.N(NUM_LIVE)) u_lat (
    .clk_i, .rst_ni, .live_i(rail_flag_i), .clr_i(lat_clr), .lat_o(lat_q)
  );

  for (genvar o = 0; o < NUM_OUT; o++) begin : g_out
    logic [1:0] hit;
    for (genvar t = 0; t < 2; t++) begin : g_term
      gpo_term #(
        .FB_W(FB_W), .NUM_GPI(NUM_GPI), .NUM_RAIL(NUM_RAIL), .NUM_FLAG(NUM_FLAG)
      ) u_term (
        .sel_i(sel[o][t]), .inv_i(inv[o][t]), .fb_i(gpo_q[FB_W-1:0]),
        .gpi_i, .live_i(rail_flag_i), .lat_i(lat_q), .mon_i(rail_mon_i),
        .hit_o(hit[t])
      );
    end
    gpo_delay #(.DLY_W(DLY_W)) u_dly (
      .clk_i, .rst_ni, .tick_i, .raw_i(|hit),
      .asrt_dly_i(asrt_dly[o]), .deas_dly_i(deas_dly[o]), .out_o(gpo_q[o])
    );
  end

  assign gpo_o = gpo_q;
endmodule

// File: rtl/gpo_logic_chk.sv
module gpo_logic_chk #(
  parameter int NUM_OUT  = 4,
  parameter int NUM_LIVE = 32,
  parameter int DLY_W    = 16
) (
  input logic                          clk_i,
  input logic                          rst_ni,
  input logic                          tick_i,
  input logic                          clr_i,
  input logic [NUM_OUT-1:0]            gpo_i,
  input logic [NUM_LIVE-1:0]           live_i,
  input logic [NUM_LIVE-1:0]           lat_i,
  input logic [NUM_OUT-1:0][DLY_W-1:0] asrt_dly_i,
  input logic [NUM_OUT-1:0][DLY_W-1:0] deas_dly_i
);
  for (genvar o = 0; o < NUM_OUT; o++) begin : g_o
    AST_RISE_ON_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(gpo_i[o]) |-> ($past(tick_i) || ($past(asrt_dly_i[o]) == '0))); // R7
    AST_FALL_ON_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(gpo_i[o]) |-> ($past(tick_i) || ($past(deas_dly_i[o]) == '0))); // R8
  end
  for (genvar k = 0; k < NUM_LIVE; k++) begin : g_k
    AST_LAT_SET_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      live_i[k] |=> lat_i[k]); // R5
    AST_LAT_RISE_SRC: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(lat_i[k]) |-> $past(live_i[k])); // R5
    AST_LAT_FALL_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(lat_i[k]) |-> $past(clr_i)); // R5
  end
endmodule

bind gpo_logic gpo_logic_chk #(
  .NUM_OUT(NUM_OUT), .NUM_LIVE(NUM_RAIL*NUM_FLAG), .DLY_W(DLY_W)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .clr_i(lat_clr),
  .gpo_i(gpo_o), .live_i(rail_flag_i), .lat_i(lat_q),
  .asrt_dly_i(asrt_dly), .deas_dly_i(deas_dly)
);

// File: tb/gpo_logic_tb.sv
module gpo_logic_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        tick = 1'b0;
  logic        we = 1'b0;
  logic [5:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [3:0]  gpi = '0;
  logic [31:0] flags = '0;
  logic [3:0]  mon = '0;
  logic [3:0]  gpo;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  logic [15:0] m_sel [4][2];
  logic [11:0] m_inv [4][2];

  always #(CLK_PERIOD/2) clk = ~clk;

  gpo_logic u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .tick_i(tick), .cfg_we_i(we),
    .cfg_addr_i(addr), .cfg_wdata_i(wdata), .gpi_i(gpi),
    .rail_flag_i(flags), .rail_mon_i(mon), .gpo_o(gpo)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cyc(int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic wr(int a, logic [31:0] d);
    @(negedge clk);
    we = 1'b1; addr = 6'(a); wdata = d;
    @(posedge clk);
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic set_term(int o, int t, logic [15:0] s, logic [11:0] v);
    m_sel[o][t] = s;
    m_inv[o][t] = v;
    wr(o*8 + t*2, {16'h0, s});
    wr(o*8 + t*2 + 1, {20'h0, v});
  endtask

  task automatic pulse_tick();
    @(negedge clk);
    tick = 1'b1;
    @(posedge clk);
    @(negedge clk);
    tick = 1'b0;
  endtask

  // term model from the requirement text
  function automatic logic m_term(logic [15:0] s, logic [11:0] v, logic [3:0] fb,
                                  logic [3:0] g, logic [31:0] fl, logic [31:0] lt,
                                  logic [3:0] mn);
    logic [3:0]  f;
    logic [3:0]  rm;
    logic [11:0] m;
    logic [11:0] x;
    logic        ok;
    for (int r = 0; r < 4; r++)
      f[r] = s[15] ? lt[r*8 + int'(s[14:12])] : fl[r*8 + int'(s[14:12])];
    rm = s[11:8];
    if (s[14:12] == 3'd0) rm = rm & mn;
    m = {rm, s[7:0]};
    x = {f, g, fb};
    ok = 1'b1;
    for (int b = 0; b < 12; b++)
      if (m[b] && ((x[b] ^ v[b]) == 1'b0)) ok = 1'b0;
    return (|m) && ok;
  endfunction

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [31:0] lf;
    logic        e;
    for (int o = 0; o < 4; o++)
      for (int t = 0; t < 2; t++) begin
        m_sel[o][t] = '0;
        m_inv[o][t] = '0;
      end
    cyc(3);
    chk("R10 reset outputs", {28'h0, gpo}, 32'h0);
    rst_ni = 1'b1;
    cyc(2);
    chk("R10 after reset, zero config", {28'h0, gpo}, 32'h0);

    // sweep configuration
    set_term(0, 0, 16'h0030, 12'h020);  // gpi0 & ~gpi1
    set_term(0, 1, 16'h00C0, 12'h000);  // gpi2 & gpi3
    set_term(1, 0, 16'h3500, 12'h400);  // ovf r0 & ~ovf r2
    set_term(1, 1, 16'h6280, 12'h000);  // gpi3 & uvw r1
    set_term(2, 0, 16'h0F00, 12'h000);  // power good all rails
    set_term(2, 1, 16'h0000, 12'hFFF);  // empty
    set_term(3, 0, 16'h0000, 12'hFFF);  // empty with inverts
    set_term(3, 1, 16'h5000, 12'h000);  // type only
    lf = 32'h1234_5678;
    for (int i = 0; i < 256; i++) begin
      lf = lf * 32'd1664525 + 32'd1013904223;
      gpi = 4'(i);
      mon = 4'(i >> 4);
      flags = lf;
      if (i[0]) begin  // complementary noise on non-selected types
        for (int r = 0; r < 4; r++)
          for (int k = 0; k < 8; k++)
            if (k != 3 && k != 6) flags[r*8+k] = ~flags[r*8+3];
      end
      cyc(1);
      for (int o = 0; o < 4; o++) begin
        e = m_term(m_sel[o][0], m_inv[o][0], 4'h0, gpi, flags, 32'h0, mon) |
            m_term(m_sel[o][1], m_inv[o][1], 4'h0, gpi, flags, 32'h0, mon);
        case (o)
          0: chk("R1 sop on pins", {31'h0, gpo[0]}, {31'h0, e});
          1: chk("R3 rail type select", {31'h0, gpo[1]}, {31'h0, e});
          2: chk("R4 power good monitor mask", {31'h0, gpo[2]}, {31'h0, e});
          default: chk("R2 empty term", {31'h0, gpo[3]}, {31'h0, e});
        endcase
      end
    end

    // sticky flags
    gpi = '0; flags = '0; mon = '0;
    set_term(3, 0, 16'hB100, 12'h000);  // latched ovf, rail 0
    wr(32, 32'h0);
    cyc(2);
    chk("R5 cleared start", {31'h0, gpo[3]}, 32'h0);
    @(negedge clk); flags[3] = 1'b1;
    @(negedge clk); flags[3] = 1'b0;
    cyc(2);
    chk("R5 latched after pulse", {31'h0, gpo[3]}, 32'h1);
    cyc(4);
    chk("R5 latch holds", {31'h0, gpo[3]}, 32'h1);
    wr(32, 32'h0);
    cyc(2);
    chk("R5 command clear", {31'h0, gpo[3]}, 32'h0);
    flags[3] = 1'b1;
    wr(32, 32'h0);
    cyc(2);
    chk("R5 set wins over clear", {31'h0, gpo[3]}, 32'h1);
    flags[3] = 1'b0;
    cyc(2);
    chk("R5 still latched", {31'h0, gpo[3]}, 32'h1);
    wr(32, 32'h0);
    cyc(2);
    chk("R5 clear after set", {31'h0, gpo[3]}, 32'h0);
    @(negedge clk); flags[11] = 1'b1;
    @(negedge clk); flags[11] = 1'b0;
    cyc(2);
    chk("R3 unselected rail latch", {31'h0, gpo[3]}, 32'h0);
    wr(32, 32'h0);
    wr(33, 32'h8);
    @(negedge clk); flags[3] = 1'b1;
    @(negedge clk); flags[3] = 1'b0;
    cyc(2);
    chk("R5 latched before pin clear", {31'h0, gpo[3]}, 32'h1);
    gpi = 4'h8;
    cyc(1);
    gpi = 4'h0;
    cyc(2);
    chk("R5 pin clear", {31'h0, gpo[3]}, 32'h0);
    wr(33, 32'h0);

    // feedback
    set_term(2, 0, 16'h0001, 12'h000);
    set_term(2, 1, 16'h0000, 12'h000);
    gpi = 4'h0;
    cyc(3);
    chk("R6 feedback idle", {31'h0, gpo[2]}, 32'h0);
    gpi = 4'h1;
    cyc(1);
    chk("R1 source output", {31'h0, gpo[0]}, 32'h1);
    chk("R6 follower lags", {31'h0, gpo[2]}, 32'h0);
    cyc(1);
    chk("R6 follower one cycle later", {31'h0, gpo[2]}, 32'h1);
    gpi = 4'h0;
    cyc(3);

    // delays
    set_term(1, 0, 16'h0010, 12'h000);
    set_term(1, 1, 16'h0000, 12'h000);
    wr(12, 32'h0002_0003);
    cyc(3);
    chk("R7 idle low", {31'h0, gpo[1]}, 32'h0);
    gpi = 4'h1;
    cyc(5);
    chk("R7 no tick no change", {31'h0, gpo[1]}, 32'h0);
    pulse_tick(); pulse_tick();
    chk("R7 two of three ticks", {31'h0, gpo[1]}, 32'h0);
    pulse_tick();
    chk("R7 third tick asserts", {31'h0, gpo[1]}, 32'h1);
    gpi = 4'h0;
    pulse_tick();
    chk("R8 one of two ticks", {31'h0, gpo[1]}, 32'h1);
    gpi = 4'h1;
    cyc(1);
    gpi = 4'h0;
    pulse_tick();
    chk("R9 deassert count restarted", {31'h0, gpo[1]}, 32'h1);
    pulse_tick();
    chk("R8 second tick deasserts", {31'h0, gpo[1]}, 32'h0);
    gpi = 4'h1;
    pulse_tick(); pulse_tick();
    gpi = 4'h0;
    cyc(1);
    gpi = 4'h1;
    pulse_tick(); pulse_tick();
    chk("R9 assert count restarted", {31'h0, gpo[1]}, 32'h0);
    pulse_tick();
    chk("R7 asserts after full count", {31'h0, gpo[1]}, 32'h1);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule